// File: doc/BRIEF.md
# DMA Buffer Chaining Sequencer

This block sits beside the data mover of one DMA channel. It decides, each time a buffer finishes, whether the channel goes on to another buffer or stops. The channel can chain buffers in two ways. In reload mode, the same settings are loaded again for each buffer. In list mode, a descriptor is read from memory for each buffer.

Software arms the channel with a one-cycle enable strobe, which sets a self-clearing enable bit. The `auto_i` bit picks the mode when the channel starts.

- **Reload mode.** Buffers repeat for as long as `auto_i` is held high. If software drops `auto_i` while a buffer is running, the sequencer marks the next buffer as the last one. That buffer runs, and then the channel stops.
- **List mode.** The sequencer fetches descriptors over a request/acknowledge handshake. A fetched descriptor ends the chain only when both of its end flags are set and its next-pointer is zero.

Two sticky status bits record the completion events: one for a finished buffer and one for a finished chain. Each status bit drives its own interrupt line through a mask bit. Software clears a status bit by writing a one to it.

Top module: `dmac_chain_ctrl`

## Requirements
- R1: In idle, an enable strobe with `auto_i`=1 starts reload mode. `load_o` pulses for one cycle after that edge, and `en_o` goes high.
- R2: In idle, an enable strobe with `auto_i`=0 starts list mode. From the next cycle, `fetch_req_o` is high and `fetch_addr_o` equals `head_ptr_i`. Both hold steady until `fetch_ack_i` is sampled. One cycle after the acknowledge, `load_o` pulses and `fetch_req_o` is low.
- R3: In reload mode, a buffer-done strobe with `auto_i` still 1 pulses `reload_o` one cycle later, and the channel stays enabled.
- R4: In reload mode, a buffer-done strobe with `auto_i`=0 still pulses `reload_o`, but it marks that new buffer as the last one. The next buffer-done strobe stops the channel.
- R5: In list mode, a buffer stops the channel when it finishes if its descriptor had both end flags at 1 and a next-pointer of 0. Any other descriptor makes the buffer-done strobe start a new fetch at that descriptor's next-pointer. This includes a zero pointer with only one end flag set.
- R6: On stop, `done_o` is high for exactly one cycle and `en_o` drops in the same cycle. The chain-complete status (bit 1) is set.
- R7: Every buffer-done strobe accepted while a buffer runs sets the buffer-complete status (bit 0). `buf_done_i` marks completion of the destination writes.
- R8: `irq_o[k]` equals status bit k ANDed with `irq_mask_i[k]`. A masked status stays sticky and shows up as soon as its mask bit is set.
- R9: `irq_clr_i[k]`=1 clears status bit k on the next edge. If a set event and a clear come in the same cycle, the set wins.
- R10: A buffer-done strobe while idle or while fetching changes no status and produces no strobe. An enable strobe while the channel is busy is ignored.
- R11: Once the channel has stopped, no `load_o` or `reload_o` appears until the next enable strobe. At most one of `load_o`, `reload_o` and `done_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_set_i | input | 1 | Enable strobe; arms the channel when it is idle |
| auto_i | input | 1 | Reload-mode control bit, owned by software |
| head_ptr_i | input | AW | Address of the first descriptor in list mode |
| irq_mask_i | input | 2 | Interrupt masks: bit 0 buffer-complete, bit 1 chain-complete |
| irq_clr_i | input | 2 | Write-one-to-clear strobes for the status bits |
| buf_done_i | input | 1 | Destination-side completion strobe for the current buffer |
| fetch_ack_i | input | 1 | Descriptor fetch acknowledge; the descriptor fields are valid with it |
| fetch_next_i | input | AW | Next-pointer field of the fetched descriptor |
| fetch_src_end_i | input | 1 | Source end flag of the fetched descriptor |
| fetch_dst_end_i | input | 1 | Destination end flag of the fetched descriptor |
| en_o | output | 1 | Channel enable; clears itself on stop |
| fetch_req_o | output | 1 | Descriptor fetch request |
| fetch_addr_o | output | AW | Address of the descriptor to fetch |
| load_o | output | 1 | Strobe: start a buffer using the newly loaded settings |
| reload_o | output | 1 | Strobe: start another buffer with the same settings |
| done_o | output | 1 | One-cycle pulse when the channel stops |
| irq_o | output | 2 | Masked interrupt lines: bit 0 buffer-complete, bit 1 chain-complete |

## Verification
Every result is registered, so each one is due on the first clock edge after the input that causes it. This covers `load_o` after an enable strobe or a fetch acknowledge, `reload_o` or `done_o` after a buffer-done strobe, and status after a set event or a clear. `fetch_req_o` and `fetch_addr_o` follow the registered state and are valid in that same cycle. `irq_o` follows the status combinationally and is valid in that same cycle.

The bench drives each input just after a rising edge and samples one time unit after the next rising edge. Every check therefore falls in the first cycle the result is due, and the one-cycle strobes are checked to be low again in the following cycle. Wait cycles between events are checked to carry no strobes.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2
  } dcc_state_e;

  localparam int unsigned IRQ_N    = 2;
  localparam int unsigned IRQ_BUF  = 0;
  localparam int unsigned IRQ_CHN  = 1;
endpackage

// File: rtl/dcc_seq.sv
module dcc_seq
  import dcc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_set_i,
  input  logic          auto_i,
  input  logic [AW-1:0] head_ptr_i,
  input  logic          buf_done_i,
  input  logic          fetch_ack_i,
  input  logic [AW-1:0] fetch_next_i,
  input  logic          fetch_src_end_i,
  input  logic          fetch_dst_end_i,
  output logic          en_o,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  output logic          load_o,
  output logic          reload_o,
  output logic          done_o,
  output logic          buf_evt_o,
  output logic          chain_evt_o
);
  dcc_state_e    state_q;
  logic          auto_mode_q;
  logic          last_q;
  logic [AW-1:0] ptr_q;
  logic          load_q, reload_q, done_q;
  logic          desc_last;

  assign desc_last = fetch_src_end_i & fetch_dst_end_i & (fetch_next_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      auto_mode_q <= 1'b0;
      last_q      <= 1'b0;
      ptr_q       <= '0;
      load_q      <= 1'b0;
      reload_q    <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      load_q   <= 1'b0;
      reload_q <= 1'b0;
      done_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (en_set_i) begin
            auto_mode_q <= auto_i;
            last_q      <= 1'b0;
            ptr_q       <= head_ptr_i;
            if (auto_i) begin
              state_q <= ST_RUN;
              load_q  <= 1'b1;
            end else begin
              state_q <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (fetch_ack_i) begin
            ptr_q   <= fetch_next_i;
            last_q  <= desc_last;
            load_q  <= 1'b1;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (buf_done_i) begin
            if (last_q) begin
              // chaining state sampled at the boundary says last buffer
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else if (auto_mode_q) begin
              reload_q <= 1'b1;
              if (!auto_i) last_q <= 1'b1;
            end else begin
              state_q <= ST_FETCH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign en_o         = (state_q != ST_IDLE);
  assign fetch_req_o  = (state_q == ST_FETCH);
  assign fetch_addr_o = ptr_q;
  assign load_o       = load_q;
  assign reload_o     = reload_q;
  assign done_o       = done_q;
  assign buf_evt_o    = (state_q == ST_RUN) & buf_done_i;
  assign chain_evt_o  = (state_q == ST_RUN) & buf_done_i & last_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !en_o);
  // R2
  fetch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && !fetch_ack_i) |=> (fetch_req_o && $stable(fetch_addr_o)));
  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_o, reload_o, done_o}));
  // R10
  idle_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && buf_done_i && !en_set_i) |=> (!en_o && !done_o && !reload_o && !load_o));
endmodule

// File: rtl/dcc_irq.sv
module dcc_irq
  import dcc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_N-1:0] set_i,
  input  logic [IRQ_N-1:0] clr_i,
  input  logic [IRQ_N-1:0] mask_i,
  output logic [IRQ_N-1:0] irq_o
);
  logic [IRQ_N-1:0] st_q;

  for (genvar k = 0; k < IRQ_N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[k] <= 1'b0;
      else         st_q[k] <= set_i[k] | (st_q[k] & ~clr_i[k]);
    end

    // R9
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> st_q[k]);
    // R9
    clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !st_q[k]);
  end

  assign irq_o = st_q & mask_i;
endmodule

// File: rtl/dmac_chain_ctrl.sv
module dmac_chain_ctrl
  import dcc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_set_i,
  input  logic          auto_i,
  input  logic [AW-1:0] head_ptr_i,
  input  logic [1:0]    irq_mask_i,
  input  logic [1:0]    irq_clr_i,
  input  logic          buf_done_i,
  input  logic          fetch_ack_i,
  input  logic [AW-1:0] fetch_next_i,
  input  logic          fetch_src_end_i,
  input  logic          fetch_dst_end_i,
  output logic          en_o,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  output logic          load_o,
  output logic          reload_o,
  output logic          done_o,
  output logic [1:0]    irq_o
);
  logic             buf_evt, chain_evt;
  logic [IRQ_N-1:0] irq_set;

  dcc_seq #(.AW(AW)) u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .en_set_i        (en_set_i),
    .auto_i          (auto_i),
    .head_ptr_i      (head_ptr_i),
    .buf_done_i      (buf_done_i),
    .fetch_ack_i     (fetch_ack_i),
    .fetch_next_i    (fetch_next_i),
    .fetch_src_end_i (fetch_src_end_i),
    .fetch_dst_end_i (fetch_dst_end_i),
    .en_o            (en_o),
    .fetch_req_o     (fetch_req_o),
    .fetch_addr_o    (fetch_addr_o),
    .load_o          (load_o),
    .reload_o        (reload_o),
    .done_o          (done_o),
    .buf_evt_o       (buf_evt),
    .chain_evt_o     (chain_evt)
  );

  always_comb begin
    irq_set          = '0;
    irq_set[IRQ_BUF] = buf_evt;
    irq_set[IRQ_CHN] = chain_evt;
  end

  dcc_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_set),
    .clr_i  (irq_clr_i),
    .mask_i (irq_mask_i),
    .irq_o  (irq_o)
  );

  // R8
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~irq_mask_i) == 2'b00);
endmodule

// File: tb/tb_dmac_chain_ctrl.sv
module tb_dmac_chain_ctrl;
  localparam int unsigned AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_set_i = 1'b0, auto_i = 1'b0, buf_done_i = 1'b0, fetch_ack_i = 1'b0;
  logic [AW-1:0] head_ptr_i = '0, fetch_next_i = '0;
  logic          fetch_src_end_i = 1'b0, fetch_dst_end_i = 1'b0;
  logic [1:0]    irq_mask_i = 2'b00, irq_clr_i = 2'b00;
  logic          en_o, fetch_req_o, load_o, reload_o, done_o;
  logic [AW-1:0] fetch_addr_o;
  logic [1:0]    irq_o;

  int checks = 0;
  int fails  = 0;
  logic [1:0] exp_st = 2'b00;

  always #4 clk_i = ~clk_i;

  dmac_chain_ctrl #(.AW(AW)) dut (.*);

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_irq();
    return exp_st & irq_mask_i;
  endfunction

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) begin
      tick();
      check("R11 no strobe while waiting", {load_o, reload_o, done_o}, 3'b000);
    end
  endtask

  task automatic run_auto(input int n, input bit poke);
    auto_i = 1'b1; en_set_i = 1'b1;
    tick(); en_set_i = 1'b0;
    check("R1 load", load_o, 1'b1);
    check("R1 en", en_o, 1'b1);
    for (int k = 0; k < n; k++) begin
      if (poke && k == 0) begin
        en_set_i = 1'b1; tick(); en_set_i = 1'b0;
        check("R10 enable while busy", {load_o, reload_o, fetch_req_o}, 3'b000);
      end
      idle_wait($urandom % 3);
      if (k == n - 2) auto_i = 1'b0;
      buf_done_i = 1'b1;
      if (k == 0) irq_clr_i = 2'b01;
      tick(); buf_done_i = 1'b0; irq_clr_i = 2'b00;
      exp_st[0] = 1'b1;
      if (k == n - 1) begin
        exp_st[1] = 1'b1;
        check("R4 stop after last reload", done_o, 1'b1);
        check("R6 en drops", en_o, 1'b0);
      end else begin
        check("R3 reload", reload_o, 1'b1);
        check("R3 still enabled", en_o, 1'b1);
      end
      check("R7 R8 R9 irq", irq_o, exp_irq());
    end
    tick();
    check("R6 done one cycle", done_o, 1'b0);
    idle_wait(2);
  endtask

  task automatic run_link(input int n, input bit stray);
    logic [AW-1:0] addr, nxt;
    logic s, d;
    addr = $urandom;
    head_ptr_i = addr; auto_i = 1'b0; en_set_i = 1'b1;
    tick(); en_set_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      check("R2 R5 fetch req", fetch_req_o, 1'b1);
      check("R2 R5 fetch addr", fetch_addr_o, addr);
      for (int w = 0; w < int'($urandom % 4); w++) begin
        if (stray && w == 0) begin
          irq_clr_i = 2'b11; tick(); irq_clr_i = 2'b00; exp_st = 2'b00;
          buf_done_i = 1'b1; tick(); buf_done_i = 1'b0;
          check("R10 done ignored in fetch", irq_o, exp_irq());
        end else tick();
        check("R2 req held", {fetch_req_o, load_o}, 2'b10);
        check("R2 addr held", fetch_addr_o, addr);
      end
      if (k == n - 1) begin
        nxt = '0; s = 1'b1; d = 1'b1;
      end else begin
        case ($urandom % 3)
          0: begin nxt = $urandom | 32'h1; s = 1'($urandom); d = 1'($urandom); end
          1: begin nxt = '0; s = 1'b1; d = 1'b0; end
          default: begin nxt = '0; s = 1'b0; d = 1'b1; end
        endcase
      end
      fetch_next_i = nxt; fetch_src_end_i = s; fetch_dst_end_i = d; fetch_ack_i = 1'b1;
      tick(); fetch_ack_i = 1'b0;
      check("R2 load after ack", {load_o, fetch_req_o}, 2'b10);
      idle_wait($urandom % 3);
      buf_done_i = 1'b1; tick(); buf_done_i = 1'b0;
      exp_st[0] = 1'b1;
      if (k == n - 1) begin
        exp_st[1] = 1'b1;
        check("R5 R6 stop on end descriptor", {done_o, en_o}, 2'b10);
      end else begin
        check("R5 continue", {done_o, en_o}, 2'b01);
      end
      check("R7 R8 irq", irq_o, exp_irq());
      addr = nxt;
    end
    tick();
    check("R6 done one cycle", done_o, 1'b0);
    idle_wait(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R11 reset state", {en_o, fetch_req_o, load_o, reload_o, done_o, irq_o}, 7'b0);
    tick(); rst_ni = 1'b1; tick();

    // R10: buffer-done in idle is ignored
    irq_mask_i = 2'b11;
    buf_done_i = 1'b1; tick(); buf_done_i = 1'b0;
    check("R10 done ignored in idle", {irq_o, en_o, reload_o, done_o}, 5'b0);

    // R8: masked status stays sticky, appears when unmasked
    irq_mask_i = 2'b00;
    run_auto(2, 1'b1);
    check("R8 masked", irq_o, 2'b00);
    irq_mask_i = 2'b11; #1;
    check("R8 sticky after unmask", irq_o, 2'b11);

    // R9: clear chain bit only
    irq_clr_i = 2'b10; tick(); irq_clr_i = 2'b00; exp_st[1] = 1'b0;
    check("R9 w1c", irq_o, 2'b01);

    run_link(1, 1'b1);
    run_link(4, 1'b1);

    for (int i = 0; i < 6; i++) begin
      irq_mask_i = 2'($urandom);
      run_auto(2 + int'($urandom % 4), 1'b0);
      irq_clr_i = 2'($urandom); tick(); exp_st &= ~irq_clr_i; irq_clr_i = 2'b00;
      check("R9 random clear", irq_o, exp_irq());
      irq_mask_i = 2'($urandom);
      run_link(1 + int'($urandom % 5), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule